// File: doc/BRIEF.md
# Watchdog Enable Qualifier

This block drives an active-low system-enable line for the actuators that a supervised processor controls. A watchdog core beside it works out the service windows. Once per clock, the core reports one of three events on single-cycle strobes: a correct service that landed inside the open window, a service that came too early, or a timeout. The core also supplies its own active-low reset output and a supply-fault level. The qualifier counts correct services that arrive in an unbroken run. It grants enable only when that run reaches a parameterised length, which is three by default.

The aim is to keep motors and other critical loads switched off while a faulty system resets itself again and again. Enable is dropped at once whenever the watchdog reset is active or the supply fault is present. Any fault event wipes out the progress made so far. After a supply fault, correct services count for nothing until the watchdog reset has been seen active again, which marks a fresh power-up.

Top module: `wdq_enable_gate`

## Requirements
- R1: While `wd_rst_n` is low, `en_n` is high in the same cycle, and service strobes seen during that time add nothing to the run.
- R2: `en_n` goes low in the cycle after the REQ_SERVICES-th consecutive `svc_ok` strobe is sampled (default 3). It stays high after fewer strobes than that.
- R3: An `svc_early` or `wd_timeout` strobe clears the run to zero, so a full REQ_SERVICES further `svc_ok` strobes are needed before enable is granted.
- R4: If enable is granted when an `svc_early` or `wd_timeout` strobe is sampled, `en_n` is high from the next cycle on.
- R5: Once granted, `en_n` stays low through any number of further `svc_ok` strobes until a fault strobe, low `wd_rst_n` or `supply_fail` occurs.
- R6: `supply_fail` high forces `en_n` high in the same cycle and clears both the run and the grant.
- R7: After `supply_fail` has been high, `svc_ok` strobes are ignored until `wd_rst_n` has been sampled low at least once.
- R8: When `svc_ok` and a fault strobe are sampled in the same cycle, the fault takes effect and the service is not counted.
- R9: After `rst_n` is released, `en_n` is high and the run is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wd_rst_n | input | 1 | Active-low reset output of the watchdog core |
| supply_fail | input | 1 | High while the supply is below its threshold |
| svc_ok | input | 1 | One-cycle strobe: service within the open window |
| svc_early | input | 1 | One-cycle strobe: service during the closed window |
| wd_timeout | input | 1 | One-cycle strobe: both windows expired without service |
| en_n | output | 1 | Active-low system enable |

## Verification
The assertions assume that the watchdog core raises each event strobe for one cycle at a time, and that enable can only fall in the cycle right after a correct service. The fault-dominance property (R8) covers the case of a good strobe arriving together with a fault. The bench changes every input on the falling clock edge. It raises one strobe per pulse, except in the single test that combines a good service with an early one on purpose. It reads `en_n` back half a cycle after the edge that registered each event.

// File: rtl/wdq_pkg.sv
package wdq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_ADVANCE = 2'd1,
        CMD_CLEAR   = 2'd2
    } wdq_cmd_e;
endpackage

// File: rtl/wdq_event_sort.sv
module wdq_event_sort
    import wdq_pkg::*;
(
    input  logic     wd_rst_n,
    input  logic     supply_fail,
    input  logic     locked,
    input  logic     svc_ok,
    input  logic     svc_early,
    input  logic     wd_timeout,
    output wdq_cmd_e cmd
);
    // Faults and resets dominate; a good service counts only when unlocked.
    always_comb begin
        if (!wd_rst_n || supply_fail || svc_early || wd_timeout) begin
            cmd = CMD_CLEAR;
        end else if (svc_ok && !locked) begin
            cmd = CMD_ADVANCE;
        end else begin
            cmd = CMD_HOLD;
        end
    end
endmodule

// File: rtl/wdq_lockout.sv
module wdq_lockout (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_rst_n,
    input  logic supply_fail,
    output logic locked
);
    typedef struct packed {
        logic lock;
    } lock_state_t;

    lock_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (supply_fail) begin
            state_d.lock = 1'b1;
        end else if (!wd_rst_n) begin
            state_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked = state_q.lock;
endmodule

// File: rtl/wdq_streak_ctr.sv
module wdq_streak_ctr
    import wdq_pkg::*;
#(
    parameter int REQ_SERVICES = 3,
    localparam int CNT_W = $clog2(REQ_SERVICES + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  wdq_cmd_e cmd,
    output logic     granted
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(REQ_SERVICES - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(REQ_SERVICES);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             grant;
    } streak_state_t;

    streak_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_CLEAR: begin
                state_d.count = '0;
                state_d.grant = 1'b0;
            end
            CMD_ADVANCE: begin
                if (!state_q.grant) begin
                    if (state_q.count == LAST_STEP) begin
                        state_d.count = FULL;
                        state_d.grant = 1'b1;
                    end else begin
                        state_d.count = state_q.count + 1'b1;
                    end
                end
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign granted = state_q.grant;
endmodule

// File: rtl/wdq_enable_gate.sv
module wdq_enable_gate
    import wdq_pkg::*;
#(
    parameter int REQ_SERVICES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_rst_n,
    input  logic supply_fail,
    input  logic svc_ok,
    input  logic svc_early,
    input  logic wd_timeout,
    output logic en_n
);
    wdq_cmd_e cmd;
    logic     lock_q;
    logic     granted;

    wdq_lockout u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_rst_n    (wd_rst_n),
        .supply_fail (supply_fail),
        .locked      (lock_q)
    );

    wdq_event_sort u_sort (
        .wd_rst_n    (wd_rst_n),
        .supply_fail (supply_fail),
        .locked      (lock_q),
        .svc_ok      (svc_ok),
        .svc_early   (svc_early),
        .wd_timeout  (wd_timeout),
        .cmd         (cmd)
    );

    wdq_streak_ctr #(
        .REQ_SERVICES (REQ_SERVICES)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .granted (granted)
    );

    // Reset and supply fault veto enable without waiting for a clock edge.
    assign en_n = !(granted && wd_rst_n && !supply_fail);
endmodule

// File: rtl/wdq_enable_gate_chk.sv
module wdq_enable_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic wd_rst_n,
    input logic supply_fail,
    input logic svc_ok,
    input logic svc_early,
    input logic wd_timeout,
    input logic lock_q,
    input logic en_n
);
    AST_RST_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_rst_n |-> en_n); // R1

    AST_FALL_AFTER_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_n) |-> $past(svc_ok)); // R2

    AST_FAULT_REVOKES: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_early || wd_timeout) |=> en_n); // R4

    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !svc_early && !wd_timeout) |=> (!en_n || !wd_rst_n || supply_fail)); // R5

    AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fail |=> en_n); // R6

    AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && en_n) |=> en_n); // R7

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && (svc_early || wd_timeout)) |=> en_n); // R8
endmodule

bind wdq_enable_gate wdq_enable_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_rst_n    (wd_rst_n),
    .supply_fail (supply_fail),
    .svc_ok      (svc_ok),
    .svc_early   (svc_early),
    .wd_timeout  (wd_timeout),
    .lock_q      (lock_q),
    .en_n        (en_n)
);

// File: tb/sim_wdq_enable_gate.sv
`timescale 1ns/1ps
module sim_wdq_enable_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_rst_n = 1'b1;
    logic supply_fail = 1'b0;
    logic svc_ok = 1'b0;
    logic svc_early = 1'b0;
    logic wd_timeout = 1'b0;
    logic en_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdq_enable_gate #(.REQ_SERVICES(3)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_rst_n    (wd_rst_n),
        .supply_fail (supply_fail),
        .svc_ok      (svc_ok),
        .svc_early   (svc_early),
        .wd_timeout  (wd_timeout),
        .en_n        (en_n)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (en_n !== exp) begin
            errors++;
            $display("FAIL %s: en_n=%b expected %b", req, en_n, exp);
        end
    endtask

    // kind: 0 good, 1 early, 2 timeout, 3 good plus early together
    task automatic pulse(input int kind);
        @(negedge clk);
        svc_ok     = (kind == 0) || (kind == 3);
        svc_early  = (kind == 1) || (kind == 3);
        wd_timeout = (kind == 2);
        @(negedge clk);
        svc_ok = 1'b0; svc_early = 1'b0; wd_timeout = 1'b0;
    endtask

    task automatic goods(input int n);
        for (int i = 0; i < n; i++) pulse(0);
    endtask

    task automatic wd_reset();
        @(negedge clk); wd_rst_n = 1'b0;
        @(negedge clk); @(negedge clk); wd_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(1'b1, "R9");
    endtask

    task automatic t_three_in_row();
        goods(2); check(1'b1, "R2");
        goods(1); check(1'b0, "R2");
        goods(4); check(1'b0, "R5");
    endtask

    task automatic t_fault_revokes();
        pulse(1); check(1'b1, "R4");
        goods(2); check(1'b1, "R3");
        goods(1); check(1'b0, "R3");
        pulse(2); check(1'b1, "R4");
    endtask

    task automatic t_streak_break();
        wd_reset();
        goods(2); pulse(2);
        goods(2); check(1'b1, "R3");
        goods(1); check(1'b0, "R3");
    endtask

    task automatic t_watchdog_reset();
        @(negedge clk); wd_rst_n = 1'b0; #1;
        check(1'b1, "R1");
        svc_ok = 1'b1;
        repeat (3) @(negedge clk);
        svc_ok = 1'b0; wd_rst_n = 1'b1;
        @(negedge clk); check(1'b1, "R1");
        goods(2); check(1'b1, "R1");
        goods(1); check(1'b0, "R1");
    endtask

    task automatic t_supply();
        @(negedge clk); supply_fail = 1'b1; #1;
        check(1'b1, "R6");
        @(negedge clk); supply_fail = 1'b0;
        @(negedge clk); check(1'b1, "R6");
        goods(3); check(1'b1, "R7");
        wd_reset();
        goods(3); check(1'b0, "R7");
    endtask

    task automatic t_tie();
        wd_reset();
        goods(2); pulse(3); check(1'b1, "R8");
        goods(2); check(1'b1, "R8");
        goods(1); check(1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_three_in_row();
        t_fault_revokes();
        t_streak_break();
        t_watchdog_reset();
        t_supply();
        t_tie();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule